// File: doc/BRIEF.md
# Virtual-Channel Output Port Multiplexer

This block is the output half of one port of a wormhole-switched on-chip router. Each virtual channel (VC) of the port's inputs presents a request, the flit at the head of its buffer, an end-of-packet flag and a ready bit that says whether that head flit is valid. An arbiter selects one requester and registers its grant. The registered one-hot grant steers a data multiplexer and a ready multiplexer that place the chosen VC's head flit on the external link. The chosen VC's ready bit becomes the link's valid signal.

Each flit that the downstream side acknowledges produces a one-cycle read strobe back to the granted VC, so that its buffer moves on to the next flit. The grant is held until the flit carrying end-of-packet has been acknowledged, which keeps a packet's flits together on the link. A new winner is chosen in either round-robin or fixed-priority order, as selected by a mode input. VCs whose clock has been gated off by a power manager take no part in arbitration.

Top module: `vcoc_output_channel`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no grant is held, `out_val`, `out_eop` and every bit of `vc_rd` are 0, and `out_data` is all zero.
- R2: With `arb_mode` = 1 (fixed priority) and no grant held, the eligible VC with the lowest index is granted. The grant is visible on `vc_grant` from the cycle after the clock edge that sampled the requests.
- R3: With `arb_mode` = 0 (round robin) and no grant held, the search for a winner starts at a pointer and wraps upward through the VC indices. The pointer is 0 after reset. Each packet release, in either mode, sets it to the index after the released VC, modulo the VC count.
- R4: `vc_grant` is either all zero or has exactly one bit set.
- R5: While VC i is granted, `out_data` equals the flit of VC i, `out_eop` its end-of-packet flag and `out_val` its ready bit. With no grant, all three are zero.
- R6: `vc_rd` has the granted VC's bit set in exactly those cycles in which `out_val` and `link_ack` are both 1, and is all zero in every other cycle.
- R7: A grant stays unchanged until a cycle in which `out_val`, `link_ack` and `out_eop` are all 1. After that edge, `vc_grant` is zero for one cycle, and no new winner is picked at that same edge.
- R8: A VC whose `vc_clk_en` bit is 0 is never granted, whatever its request. Clearing the enable of a VC that already holds the grant does not take the grant away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arb_mode | input | 1 | 0 selects round robin, 1 selects fixed priority (lowest index first) |
| vc_clk_en | input | NUM_VC | Per-VC clock enable; a 0 means the VC is powered down |
| vc_req | input | NUM_VC | Per-VC request toward this output |
| vc_rok | input | NUM_VC | Per-VC ready: the head flit of the VC's buffer is valid |
| vc_eop | input | NUM_VC | Per-VC end-of-packet flag of the head flit |
| vc_data | input | NUM_VC*FLIT_W | Head flits of all VCs; VC i occupies bits [i*FLIT_W +: FLIT_W] |
| link_ack | input | 1 | Downstream acknowledge of the flit on the link |
| out_data | output | FLIT_W | Flit driven onto the link |
| out_eop | output | 1 | End-of-packet flag of the flit on the link |
| out_val | output | 1 | Link valid |
| vc_rd | output | NUM_VC | One-hot, one-cycle read strobe back to the granted VC |
| vc_grant | output | NUM_VC | Registered one-hot grant |

## Verification
Two events can meet in one cycle: the acknowledged end-of-packet flit that releases a grant, and fresh requests from other VCs, possibly with a change of arbitration mode or clock enables. The bench creates this overlap on purpose in directed sequences. It also lets it arise often in a long stretch of random requests, ready bits, flags, enables and acknowledges. A behavioural model compares every output in every cycle. It expects the release edge to clear the grant without granting anyone. In the following cycle it expects a pick made from the pointer moved past the released VC.

// File: rtl/vcoc_pkg.sv
package vcoc_pkg;

    typedef enum logic {
        ARB_ROUND_ROBIN = 1'b0,
        ARB_FIXED_PRIO  = 1'b1
    } arb_mode_e;

endpackage

// File: rtl/vcoc_arbiter.sv
module vcoc_arbiter
    import vcoc_pkg::*;
#(
    parameter int NUM_VC = 4,
    parameter int IDX_W  = 2
) (
    input  logic [NUM_VC-1:0] eligible,
    input  logic [IDX_W-1:0]  ptr,
    input  arb_mode_e         mode,
    output logic [NUM_VC-1:0] pick
);

    logic found;
    int   cand;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        cand  = 0;
        for (int k = 0; k < NUM_VC; k++) begin
            if (mode == ARB_FIXED_PRIO) begin
                cand = k;
            end else begin
                cand = (int'(ptr) + k) % NUM_VC;
            end
            if (!found && eligible[cand]) begin
                pick[cand] = 1'b1;
                found      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/vcoc_switch.sv
module vcoc_switch #(
    parameter int NUM_VC = 4,
    parameter int FLIT_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_VC-1:0]        grant,
    input  logic [NUM_VC*FLIT_W-1:0] vc_data,
    input  logic [NUM_VC-1:0]        vc_eop,
    input  logic [NUM_VC-1:0]        vc_rok,
    output logic [FLIT_W-1:0]        out_data,
    output logic                     out_eop,
    output logic                     out_val
);

    logic [FLIT_W-1:0] masked [NUM_VC];

    for (genvar g = 0; g < NUM_VC; g++) begin : g_lane
        assign masked[g] = vc_data[g*FLIT_W +: FLIT_W] & {FLIT_W{grant[g]}};
    end

    always_comb begin
        out_data = '0;
        for (int i = 0; i < NUM_VC; i++) begin
            out_data = out_data | masked[i];
        end
        out_eop = |(grant & vc_eop);
        out_val = |(grant & vc_rok);
    end

    // R5: an idle output never claims a valid flit
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0) |-> (!out_val && !out_eop && out_data == '0));

endmodule

// File: rtl/vcoc_flow.sv
module vcoc_flow #(
    parameter int NUM_VC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_VC-1:0] grant,
    input  logic              out_val,
    input  logic              out_eop,
    input  logic              link_ack,
    output logic [NUM_VC-1:0] vc_rd,
    output logic              last_xfer
);

    logic xfer;

    always_comb begin
        xfer      = out_val && link_ack;
        vc_rd     = grant & {NUM_VC{xfer}};
        last_xfer = xfer && out_eop;
    end

    // R6: read strobe is one-hot and only appears with an acknowledge
    a_r6_rd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vc_rd));
    a_r6_rd_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (vc_rd != '0) |-> link_ack);

endmodule

// File: rtl/vcoc_output_channel.sv
module vcoc_output_channel
    import vcoc_pkg::*;
#(
    parameter int NUM_VC = 4,
    parameter int FLIT_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     arb_mode,
    input  logic [NUM_VC-1:0]        vc_clk_en,
    input  logic [NUM_VC-1:0]        vc_req,
    input  logic [NUM_VC-1:0]        vc_rok,
    input  logic [NUM_VC-1:0]        vc_eop,
    input  logic [NUM_VC*FLIT_W-1:0] vc_data,
    input  logic                     link_ack,
    output logic [FLIT_W-1:0]        out_data,
    output logic                     out_eop,
    output logic                     out_val,
    output logic [NUM_VC-1:0]        vc_rd,
    output logic [NUM_VC-1:0]        vc_grant
);

    localparam int IDX_W = (NUM_VC > 1) ? $clog2(NUM_VC) : 1;

    typedef struct packed {
        logic [NUM_VC-1:0] grant;
        logic [IDX_W-1:0]  ptr;
    } state_t;

    state_t st_q, st_d;

    logic [NUM_VC-1:0] eligible;
    logic [NUM_VC-1:0] pick;
    logic [IDX_W-1:0]  win_idx;
    logic              last_xfer;

    assign eligible = vc_req & vc_clk_en;

    vcoc_arbiter #(.NUM_VC(NUM_VC), .IDX_W(IDX_W)) u_arb (
        .eligible (eligible),
        .ptr      (st_q.ptr),
        .mode     (arb_mode_e'(arb_mode)),
        .pick     (pick)
    );

    vcoc_switch #(.NUM_VC(NUM_VC), .FLIT_W(FLIT_W)) u_sw (
        .clk      (clk),
        .rst_n    (rst_n),
        .grant    (st_q.grant),
        .vc_data  (vc_data),
        .vc_eop   (vc_eop),
        .vc_rok   (vc_rok),
        .out_data (out_data),
        .out_eop  (out_eop),
        .out_val  (out_val)
    );

    vcoc_flow #(.NUM_VC(NUM_VC)) u_flow (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant     (st_q.grant),
        .out_val   (out_val),
        .out_eop   (out_eop),
        .link_ack  (link_ack),
        .vc_rd     (vc_rd),
        .last_xfer (last_xfer)
    );

    always_comb begin
        st_d    = st_q;
        win_idx = '0;
        for (int i = 0; i < NUM_VC; i++) begin
            if (st_q.grant[i]) begin
                win_idx = IDX_W'(i);
            end
        end
        if (st_q.grant != '0) begin
            if (last_xfer) begin
                st_d.grant = '0;
                if (int'(win_idx) == NUM_VC - 1) begin
                    st_d.ptr = '0;
                end else begin
                    st_d.ptr = win_idx + 1'b1;
                end
            end
        end else begin
            st_d.grant = pick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vc_grant = st_q.grant;

    // R4: at most one VC owns the output
    a_r4_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vc_grant));

    // R7: grant is frozen until the last flit is acknowledged
    a_r7_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (vc_grant != '0 && !(out_val && link_ack && out_eop)) |=> $stable(vc_grant));

    // R7: the last acknowledged flit frees the output for one cycle
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (vc_grant != '0 && out_val && link_ack && out_eop) |=> (vc_grant == '0));

    // R8: a fresh grant always goes to a requesting, clocked VC
    a_r8_gated_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (vc_grant != '0 && $past(vc_grant) == '0)
            |-> ((vc_grant & $past(vc_req & vc_clk_en)) != '0));

    // R2: fixed priority never skips a lower eligible index
    a_r2_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        (vc_grant != '0 && $past(vc_grant) == '0 && $past(arb_mode))
            |-> (($past(vc_req & vc_clk_en) & (vc_grant - 1'b1)) == '0));

endmodule

// File: tb/vcoc_output_channel_test.sv
module vcoc_output_channel_test;

    localparam int N = 4;
    localparam int W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             arb_mode = 1'b0;
    logic [N-1:0]     vc_clk_en = '0;
    logic [N-1:0]     vc_req = '0;
    logic [N-1:0]     vc_rok = '0;
    logic [N-1:0]     vc_eop = '0;
    logic [N*W-1:0]   vc_data = '0;
    logic             link_ack = 1'b0;
    logic [W-1:0]     out_data;
    logic             out_eop;
    logic             out_val;
    logic [N-1:0]     vc_rd;
    logic [N-1:0]     vc_grant;

    int checks = 0;
    int fails  = 0;
    int mgrant = -1;
    int mptr   = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    vcoc_output_channel #(.NUM_VC(N), .FLIT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .arb_mode(arb_mode), .vc_clk_en(vc_clk_en),
        .vc_req(vc_req), .vc_rok(vc_rok), .vc_eop(vc_eop), .vc_data(vc_data),
        .link_ack(link_ack), .out_data(out_data), .out_eop(out_eop),
        .out_val(out_val), .vc_rd(vc_rd), .vc_grant(vc_grant)
    );

    task automatic check(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare outputs with the model, then advance the model one clock
    task automatic step();
        logic [N-1:0] eg, egr, erd;
        logic         ev, ee;
        logic [W-1:0] ed;
        #1;
        eg = '0; ev = 1'b0; ee = 1'b0; ed = '0; erd = '0;
        if (mgrant >= 0) begin
            eg[mgrant] = 1'b1;
            ev = vc_rok[mgrant];
            ee = vc_eop[mgrant];
            ed = vc_data[mgrant*W +: W];
            if (ev && link_ack) erd[mgrant] = 1'b1;
        end
        check(tag, "grant", W'(vc_grant), W'(eg));
        check("R4", "grant ones", W'($countones(vc_grant) > 1), '0);
        check("R5", "out_val", W'(out_val), W'(ev));
        check("R5", "out_eop", W'(out_eop), W'(ee));
        check("R5", "out_data", out_data, ed);
        check("R6", "vc_rd", W'(vc_rd), W'(erd));
        if (rst_n) begin
            if (mgrant >= 0) begin
                if (ev && link_ack && ee) begin
                    mptr   = (mgrant + 1) % N;
                    mgrant = -1;
                end
            end else begin
                egr = vc_req & vc_clk_en;
                for (int k = 0; k < N; k++) begin
                    int c;
                    c = arb_mode ? k : (mptr + k) % N;
                    if (mgrant < 0 && egr[c]) mgrant = c;
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic drive(input logic [N-1:0] req, input logic [N-1:0] rok,
                         input logic [N-1:0] eop, input logic ack);
        vc_req = req; vc_rok = rok; vc_eop = eop; link_ack = ack;
        for (int i = 0; i < N; i++) vc_data[i*W +: W] = $urandom;
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: reset state, even with requests present
        @(negedge clk);
        vc_clk_en = '1;
        tag = "R1";
        drive(4'b1111, 4'b1111, 4'b0000, 1'b1);
        drive(4'b1111, 4'b1111, 4'b0000, 1'b1);
        rst_n = 1'b1;
        drive(4'b0000, 4'b1111, 4'b0000, 1'b1);

        // R2: fixed priority picks the lowest eligible index
        tag = "R2"; arb_mode = 1'b1;
        drive(4'b1100, 4'b1111, 4'b0000, 1'b0);
        drive(4'b1111, 4'b1111, 4'b0000, 1'b0);
        drive(4'b1111, 4'b1111, 4'b1111, 1'b1);
        drive(4'b1110, 4'b1111, 4'b0000, 1'b0);
        drive(4'b1110, 4'b1111, 4'b1111, 1'b1);
        drive(4'b0000, 4'b0000, 4'b0000, 1'b0);

        // R3: round robin rotates through all requesters
        tag = "R3"; arb_mode = 1'b0;
        for (int i = 0; i < 12; i++) drive(4'b1111, 4'b1111, 4'b1111, 1'b1);
        drive(4'b0101, 4'b1111, 4'b1111, 1'b1);
        drive(4'b0101, 4'b1111, 4'b1111, 1'b1);
        drive(4'b0101, 4'b1111, 4'b1111, 1'b1);

        // R7: multi-flit packet keeps the grant; release and new request coincide
        tag = "R7";
        drive(4'b0010, 4'b1111, 4'b0000, 1'b0);
        for (int i = 0; i < 5; i++) drive(4'b1111, 4'b1111, 4'b0000, 1'b1);
        drive(4'b1111, 4'b1111, 4'b1111, 1'b0);
        drive(4'b1111, 4'b1111, 4'b1111, 1'b1);
        drive(4'b1111, 4'b1111, 4'b0000, 1'b1);

        // R6: acknowledge without ready gives no read strobe
        tag = "R6";
        drive(4'b1111, 4'b0000, 4'b1111, 1'b1);
        drive(4'b1111, 4'b0000, 4'b1111, 1'b1);
        drive(4'b0000, 4'b1111, 4'b1111, 1'b1);
        drive(4'b0000, 4'b0000, 4'b0000, 1'b1);

        // R8: gated VCs are ignored; gating the owner keeps its grant
        tag = "R8"; vc_clk_en = 4'b0010;
        drive(4'b1111, 4'b1111, 4'b0000, 1'b0);
        drive(4'b1111, 4'b1111, 4'b0000, 1'b0);
        vc_clk_en = 4'b0000;
        drive(4'b1111, 4'b1111, 4'b0000, 1'b1);
        drive(4'b1111, 4'b1111, 4'b1111, 1'b1);
        drive(4'b1111, 4'b1111, 4'b1111, 1'b1);
        drive(4'b1111, 4'b1111, 4'b1111, 1'b1);
        vc_clk_en = 4'b1111;

        // R7: random traffic, modes and enables mixed
        tag = "R7";
        for (int i = 0; i < 4000; i++) begin
            if (i % 150 == 0) arb_mode = $urandom_range(0, 1);
            if (i % 37 == 0) vc_clk_en = N'($urandom);
            drive(N'($urandom), N'($urandom | $urandom), N'($urandom & $urandom),
                  1'($urandom));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule